// File: doc/BRIEF.md
# Video Sync Word Mapper

This block is a registered front-end stage for a parallel-to-serial video link. On each rising edge of the parallel clock it captures a 10-bit word. It checks whether the word is one of the reserved timing-reference values. If it is, the block rewrites the two least significant bits so that the word becomes a legal 10-bit sync code. This lets an 8-bit source, which leaves those two bits undefined, still produce valid sync codes on a 10-bit link.

The decision looks only at the upper eight bits. Every code in 000–003 therefore becomes 000, and every code in 3FC–3FF becomes 3FF. A one-cycle flag marks each output word that was recognised as reserved. A disable input turns the mapping off, so that data in non-video formats passes through untouched. All other words pass through bit-exact in both settings.

Internally, a classifier sorts each word into one of three classes: plain, low-reserved and high-reserved. A rewrite stage uses the class to force the low bits. An output register then holds the result together with the flag. The block has no sequencing state: each output depends only on the word captured one edge earlier.

Top module: `sync_word_mapper`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `dout` to 000 and `rsv_flag` to 0; these values are visible in the first cycle after reset is released.
- R2: The result for a word presented at a rising edge appears on `dout` and `rsv_flag` right after that edge and holds for one cycle (latency of one register).
- R3: With `sync_dis` low, a word whose bits 9..2 are all 0 is output as 000, whatever its bits 1..0 are.
- R4: With `sync_dis` low, a word whose bits 9..2 are all 1 is output as 3FF, whatever its bits 1..0 are.
- R5: `rsv_flag` is 1 exactly in the cycles where the output word was mapped under R3 or R4, and 0 in every other cycle.
- R6: With `sync_dis` high, every word, including 000–003 and 3FC–3FF, is output unchanged, and `rsv_flag` stays 0.
- R7: A word whose bits 9..2 are neither all 0 nor all 1 is output bit-exact, with `rsv_flag` 0, whatever the level of `sync_dis`.
- R8: Bits 1..0 take no part in the decision; bit 9 is the MSB and bit 0 the LSB. For example, 004 and 3FB are not reserved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel word clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sync_dis | input | 1 | High: mapping off, words pass through unchanged |
| din | input | 10 | Parallel input word, bit 0 is the LSB |
| dout | output | 10 | Registered, mapped output word |
| rsv_flag | output | 1 | High in the cycle where `dout` carries a mapped reserved word |

## Verification
The properties assume that `din` and `sync_dis` are stable around each rising edge. They also assume that reset is applied at least once before the results are relied on; results are checked only once a cycle with reset low has passed. The stimulus meets the first assumption by changing inputs only on falling edges. It meets the second by opening with a multi-cycle reset, and it later asserts reset again in the middle of traffic. The bench walks through every 10-bit value with the disable low and with it high, so the boundary codes next to both reserved ranges are always reached.

// File: rtl/vsm_pkg.sv
package vsm_pkg;

    // Class of a captured word, decided from its upper bits only.
    typedef enum logic [1:0] {
        CLS_PLAIN = 2'd0,
        CLS_LOW   = 2'd1,
        CLS_HIGH  = 2'd2
    } word_class_e;

endpackage

// File: rtl/vsm_classify.sv
module vsm_classify
    import vsm_pkg::*;
#(
    parameter int DATA_W  = 10,
    parameter int FORCE_W = 2
) (
    input  logic [DATA_W-1:0] word,
    input  logic              map_en,
    output word_class_e       cls
);
    localparam int UPPER_W = DATA_W - FORCE_W;

    logic [UPPER_W-1:0] upper;
    logic               all_zero;
    logic               all_one;
    logic [FORCE_W-1:0] low_unused;

    assign upper      = word[DATA_W-1:FORCE_W];
    assign low_unused = word[FORCE_W-1:0];
    assign all_zero   = ~|upper;
    assign all_one    = &upper;

    always_comb begin
        cls = CLS_PLAIN;
        if (map_en && all_zero) begin
            cls = CLS_LOW;
        end else if (map_en && all_one) begin
            cls = CLS_HIGH;
        end
    end

    // Low bits deliberately take no part in the decision.
    logic unused_ok;
    assign unused_ok = ^low_unused;
endmodule

// File: rtl/vsm_rewrite.sv
module vsm_rewrite
    import vsm_pkg::*;
#(
    parameter int DATA_W  = 10,
    parameter int FORCE_W = 2
) (
    input  logic [DATA_W-1:0] word_in,
    input  word_class_e       cls,
    output logic [DATA_W-1:0] word_out,
    output logic              reserved
);
    logic [FORCE_W-1:0] low_bits;

    always_comb begin
        low_bits = word_in[FORCE_W-1:0];
        reserved = 1'b0;
        unique case (cls)
            CLS_LOW: begin
                low_bits = '0;
                reserved = 1'b1;
            end
            CLS_HIGH: begin
                low_bits = '1;
                reserved = 1'b1;
            end
            default: begin
                low_bits = word_in[FORCE_W-1:0];
                reserved = 1'b0;
            end
        endcase
    end

    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_bit
            if (gi < FORCE_W) begin : g_forced
                assign word_out[gi] = low_bits[gi];
            end else begin : g_pass
                assign word_out[gi] = word_in[gi];
            end
        end
    endgenerate
endmodule

// File: rtl/vsm_out_reg.sv
module vsm_out_reg #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] d_word,
    input  logic              d_flag,
    output logic [DATA_W-1:0] q_word,
    output logic              q_flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_word <= '0;
            q_flag <= 1'b0;
        end else begin
            q_word <= d_word;
            q_flag <= d_flag;
        end
    end
endmodule

// File: rtl/sync_word_mapper.sv
module sync_word_mapper
    import vsm_pkg::*;
#(
    parameter int DATA_W  = 10,
    parameter int FORCE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_dis,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              rsv_flag
);
    word_class_e       cls;
    logic [DATA_W-1:0] mapped;
    logic              is_rsv;

    vsm_classify #(.DATA_W(DATA_W), .FORCE_W(FORCE_W)) u_classify (
        .word   (din),
        .map_en (~sync_dis),
        .cls    (cls)
    );

    vsm_rewrite #(.DATA_W(DATA_W), .FORCE_W(FORCE_W)) u_rewrite (
        .word_in  (din),
        .cls      (cls),
        .word_out (mapped),
        .reserved (is_rsv)
    );

    vsm_out_reg #(.DATA_W(DATA_W)) u_out (
        .clk    (clk),
        .rst    (rst),
        .d_word (mapped),
        .d_flag (is_rsv),
        .q_word (dout),
        .q_flag (rsv_flag)
    );
endmodule

// File: rtl/sync_word_mapper_chk.sv
module sync_word_mapper_chk #(
    parameter int DATA_W  = 10,
    parameter int FORCE_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              sync_dis,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic              rsv_flag
);
    localparam int UPPER_W = DATA_W - FORCE_W;

    logic armed;
    logic rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R1: first cycle after reset shows cleared outputs
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        rst_d |-> (dout == '0) && !rsv_flag);

    // R3: low reserved range collapses to zero with flag
    a_r3_low_map: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(sync_dis) && ($past(din[DATA_W-1:FORCE_W]) == '0))
        |-> (dout == '0) && rsv_flag);

    // R4: high reserved range collapses to all ones with flag
    a_r4_high_map: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(sync_dis) && ($past(din[DATA_W-1:FORCE_W]) == {UPPER_W{1'b1}}))
        |-> (dout == '1) && rsv_flag);

    // R6: disable passes every word unchanged, no flag
    a_r6_bypass: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(sync_dis)) |-> (dout == $past(din)) && !rsv_flag);

    // R7: ordinary words are bit-exact, no flag
    a_r7_plain: assert property (@(posedge clk) disable iff (rst)
        (armed && ($past(din[DATA_W-1:FORCE_W]) != '0)
               && ($past(din[DATA_W-1:FORCE_W]) != {UPPER_W{1'b1}}))
        |-> (dout == $past(din)) && !rsv_flag);
endmodule

bind sync_word_mapper sync_word_mapper_chk #(.DATA_W(DATA_W), .FORCE_W(FORCE_W)) u_chk (.*);

// File: tb/sync_word_mapper_bench.sv
module sync_word_mapper_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_dis = 1'b0;
    logic [9:0] din = '0;
    logic [9:0] dout;
    logic       rsv_flag;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    typedef struct {
        logic [9:0] data;
        logic       flag;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_word_mapper u_sync_word_mapper (
        .clk(clk), .rst(rst), .sync_dis(sync_dis),
        .din(din), .dout(dout), .rsv_flag(rsv_flag)
    );

    // Driver: change inputs on the falling edge, queue the expected result.
    task automatic drive(input logic r, input logic dis, input logic [9:0] w, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; sync_dis = dis; din = w;
        e.tag = tag;
        if (r) begin
            e.data = '0; e.flag = 1'b0;
        end else if (!dis && w[9:2] == 8'h00) begin
            e.data = 10'h000; e.flag = 1'b1;
        end else if (!dis && w[9:2] == 8'hFF) begin
            e.data = 10'h3FF; e.flag = 1'b1;
        end else begin
            e.data = w; e.flag = 1'b0;
        end
        sb.push_back(e);
    endtask

    // Monitor: a quarter period after each rising edge, compare one item.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            vectors++;
            if (dout !== e.data || rsv_flag !== e.flag) begin
                miscompares++;
                $display("FAIL %s: got dout=%03h flag=%b, expected dout=%03h flag=%b",
                         e.tag, dout, rsv_flag, e.data, e.flag);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R1: reset held with a reserved word on the input
        drive(1'b1, 1'b0, 10'h3FF, "R1");
        drive(1'b1, 1'b0, 10'h001, "R1");
        drive(1'b1, 1'b1, 10'h2AA, "R1");
        // R3: whole low range, R5 flag set
        for (int i = 0; i < 4; i++) drive(1'b0, 1'b0, 10'(i), "R3");
        // R4: whole high range, R5 flag set
        for (int i = 'h3FC; i < 'h400; i++) drive(1'b0, 1'b0, 10'(i), "R4");
        // R8: neighbours of the reserved ranges
        drive(1'b0, 1'b0, 10'h004, "R8");
        drive(1'b0, 1'b0, 10'h3FB, "R8");
        drive(1'b0, 1'b0, 10'h1FF, "R8");
        drive(1'b0, 1'b0, 10'h200, "R8");
        // R6: disable high, reserved words unchanged, no flag
        drive(1'b0, 1'b1, 10'h001, "R6");
        drive(1'b0, 1'b1, 10'h3FE, "R6");
        drive(1'b0, 1'b1, 10'h003, "R6");
        drive(1'b0, 1'b1, 10'h3FC, "R6");
        // R7: ordinary words under both disable levels
        drive(1'b0, 1'b1, 10'h155, "R7");
        drive(1'b0, 1'b0, 10'h155, "R7");
        drive(1'b0, 1'b0, 10'h0FF, "R7");
        // R5: flag drops right after a reserved word
        drive(1'b0, 1'b0, 10'h3FD, "R5");
        drive(1'b0, 1'b0, 10'h2AB, "R5");
        drive(1'b0, 1'b0, 10'h002, "R5");
        drive(1'b0, 1'b1, 10'h002, "R5");
        // R1: reset in the middle of traffic
        drive(1'b1, 1'b0, 10'h3FF, "R1");
        drive(1'b0, 1'b0, 10'h123, "R2");
        // R2: full sweep, disable low then high, one result per cycle
        for (int i = 0; i < 1024; i++) drive(1'b0, 1'b0, 10'(i), "R2");
        for (int i = 1023; i >= 0; i--) drive(1'b0, 1'b1, 10'(i), "R2");
        // drain the scoreboard
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule